// File: doc/BRIEF.md
# Looped Command Sequence Generator

This block sends a short, programmable series of serial commands to a device under test and repeats the series a set number of times with no further host action. A typical series is a calibration-pulse command and then a trigger command. Each step has its own command word, its own bit length and its own idle gap. The gap is the number of clock cycles the line stays low after that command and before the next one.

A host fills up to four step slots through a simple write port. It selects how many slots take part and sets the loop count, then pulses start. The block shifts each command out on one serial line, MSB first, at one bit per clock. While the run is in progress it reports busy and the index of the current loop. When every loop has finished it raises a one-cycle done pulse. In the system the clock is 40 MHz, but the logic is not tied to any frequency.

Top module: `cmdseq_top`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `ser_out` are 0 and `loop_idx` is 0.
- R2: A write (`cfg_we`=1) while idle stores word, length and gap into slot `cfg_slot`, and later runs use the stored values. A write while `busy`=1 is ignored and leaves the slot unchanged.
- R3: A start pulse seen at a clock edge while idle, with `cfg_loops`≠0, makes `busy` 1 from the next cycle. In that same cycle `ser_out` carries the first bit of slot 0. `cfg_last` and `cfg_loops` are captured at this edge.
- R4: A command of length L (1..32) sends bits L-1 down to 0 of its word, one per cycle. A length above 32 is treated as 32. A length of 0 gives a single low cycle in place of command bits.
- R5: After each command's last bit the line stays low for exactly that slot's gap cycles. A gap of 0 makes the next command's first bit follow at once. `ser_out` is 0 whenever `busy` is 0.
- R6: Slots 0 to `cfg_last` are sent in ascending order, and the whole series repeats `cfg_loops` times. `loop_idx` holds the 0-based number of the loop in progress.
- R7: `done` is 1 for exactly one cycle, the cycle right after the final gap cycle of the last loop (or after the last bit when that gap is 0). `busy` is 0 in that cycle.
- R8: A start with `cfg_loops`=0 sends nothing, keeps `busy` at 0 and pulses `done` in the next cycle.
- R9: A start pulse while `busy`=1 is ignored, and the run in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_slot | input | 2 | Slot being written |
| cfg_word | input | 32 | Command word, right-aligned |
| cfg_len | input | 6 | Command length in bits |
| cfg_gap | input | 16 | Idle cycles after the command |
| cfg_last | input | 2 | Index of the last slot in the series |
| cfg_loops | input | 8 | Number of times the series is sent |
| start | input | 1 | Start pulse |
| ser_out | output | 1 | Serial command line |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| loop_idx | output | 8 | Current loop number |

## Verification
Some properties are checked by assertions on every cycle: done lasts one cycle and never overlaps busy, the line is low whenever the block is idle, a valid start leads to busy or to an immediate done, and the loop index stays below the captured count. Other behaviours only show up in the bench's scenarios. These are the exact bit order and length clamping, the gap lengths, the slot order across loops, that a start or a write during a run has no effect, and the cycle in which done appears. The bench sweeps loop counts 0 to 3, every series length, and three slot patterns that mix zero, short, full and over-long lengths with zero and non-zero gaps.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
    parameter int unsigned SLOTS  = 4;
    parameter int unsigned WORD_W = 32;
    parameter int unsigned LEN_W  = 6;
    parameter int unsigned GAP_W  = 16;
    parameter int unsigned LOOP_W = 8;

    localparam int unsigned SLOT_W = $clog2(SLOTS);
    localparam int unsigned CNT_W  = LEN_W + 1;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LEN_W-1:0]  len;
        logic [GAP_W-1:0]  gap;
    } step_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_GAP  = 2'd2
    } phase_t;

    // Number of cycles a step's command part takes (zero length still takes one)
    function automatic logic [CNT_W-1:0] eff_len(input logic [LEN_W-1:0] len);
        if (len == '0)
            return CNT_W'(1);
        else if (len > LEN_W'(WORD_W))
            return CNT_W'(WORD_W);
        else
            return {1'b0, len};
    endfunction

    // Left-justify the active bits so the MSB of the command sits at the top
    function automatic logic [WORD_W-1:0] align_word(input logic [WORD_W-1:0] w,
                                                     input logic [LEN_W-1:0]  len);
        logic [CNT_W-1:0] n;
        n = eff_len(len);
        if (len == '0)
            return '0;
        return w << (WORD_W - int'(n));
    endfunction
endpackage

// File: rtl/cmdseq_store.sv
module cmdseq_store
    import cmdseq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  logic [SLOT_W-1:0]        waddr_i,
    input  step_t                    wstep_i,
    output step_t [SLOTS-1:0]        table_o
);
    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    table_o[g] <= '0;
                else if (we_i && waddr_i == SLOT_W'(g))
                    table_o[g] <= wstep_i;
            end
        end
    endgenerate
endmodule

// File: rtl/cmdseq_shifter.sv
module cmdseq_shifter
    import cmdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);
    logic [WORD_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            sreg_q <= align_word(word_i, len_i);
            cnt_q  <= eff_len(len_i);
        end else if (shift_i) begin
            sreg_q <= sreg_q << 1;
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    assign bit_o  = sreg_q[WORD_W-1];
    assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
    import cmdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [SLOT_W-1:0] last_i,
    input  logic [LOOP_W-1:0] loops_i,
    input  logic [GAP_W-1:0]  gap_i,
    input  logic              sh_last_i,
    output logic              load_o,
    output logic              shift_o,
    output logic [SLOT_W-1:0] step_o,
    output logic [SLOT_W-1:0] nxt_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [LOOP_W-1:0] loop_o
);
    phase_t            phase_q;
    logic [SLOT_W-1:0] last_q;
    logic [LOOP_W-1:0] loops_q;
    logic [GAP_W-1:0]  gcnt_q;
    logic              go_run, go_zero, advance, final_step;

    assign go_run     = (phase_q == PH_IDLE) && start_i && (loops_i != '0);
    assign go_zero    = (phase_q == PH_IDLE) && start_i && (loops_i == '0);
    assign advance    = ((phase_q == PH_SEND) && sh_last_i && (gap_i == '0)) ||
                        ((phase_q == PH_GAP)  && (gcnt_q == GAP_W'(1)));
    assign final_step = (step_o == last_q) && (loop_o == loops_q - LOOP_W'(1));

    assign nxt_o   = (phase_q == PH_IDLE || step_o == last_q) ? '0 : step_o + SLOT_W'(1);
    assign load_o  = go_run || (advance && !final_step);
    assign shift_o = (phase_q == PH_SEND);
    assign busy_o  = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            last_q  <= '0;
            loops_q <= '0;
            gcnt_q  <= '0;
            step_o  <= '0;
            loop_o  <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= go_zero || (advance && final_step);
            unique case (phase_q)
                PH_IDLE: begin
                    if (go_run) begin
                        phase_q <= PH_SEND;
                        last_q  <= last_i;
                        loops_q <= loops_i;
                        step_o  <= '0;
                        loop_o  <= '0;
                    end
                end
                PH_SEND: begin
                    if (sh_last_i && gap_i != '0) begin
                        phase_q <= PH_GAP;
                        gcnt_q  <= gap_i;
                    end
                end
                PH_GAP: begin
                    gcnt_q <= gcnt_q - GAP_W'(1);
                end
                default: phase_q <= PH_IDLE;
            endcase
            if (advance) begin
                if (final_step) begin
                    phase_q <= PH_IDLE;
                end else begin
                    phase_q <= PH_SEND;
                    step_o  <= nxt_o;
                    if (step_o == last_q)
                        loop_o <= loop_o + LOOP_W'(1);
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R7
    AST_ZERO_LOOPS: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && loops_i == '0) |=> (done_o && !busy_o)); // R8
    AST_START_RUN: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && loops_i != '0) |=> busy_o); // R3
    AST_LOOP_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (loop_o < loops_q)); // R6
endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [SLOT_W-1:0] cfg_last,
    input  logic [LOOP_W-1:0] cfg_loops,
    input  logic              start,
    output logic              ser_out,
    output logic              busy,
    output logic              done,
    output logic [LOOP_W-1:0] loop_idx
);
    step_t [SLOTS-1:0] table_w;
    step_t             wstep;
    logic              load, shift, bit_w, sh_last;
    logic [SLOT_W-1:0] step_idx, nxt_idx;

    assign wstep = '{word: cfg_word, len: cfg_len, gap: cfg_gap};

    cmdseq_store u_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we && !busy),
        .waddr_i (cfg_slot),
        .wstep_i (wstep),
        .table_o (table_w)
    );

    cmdseq_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .word_i  (table_w[nxt_idx].word),
        .len_i   (table_w[nxt_idx].len),
        .shift_i (shift),
        .bit_o   (bit_w),
        .last_o  (sh_last)
    );

    cmdseq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .last_i    (cfg_last),
        .loops_i   (cfg_loops),
        .gap_i     (table_w[step_idx].gap),
        .sh_last_i (sh_last),
        .load_o    (load),
        .shift_o   (shift),
        .step_o    (step_idx),
        .nxt_o     (nxt_idx),
        .busy_o    (busy),
        .done_o    (done),
        .loop_o    (loop_idx)
    );

    assign ser_out = shift && bit_w;

    AST_LINE_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ser_out); // R5
endmodule

// File: tb/tb_cmdseq_top.sv
module tb_cmdseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic [31:0] cfg_word = '0;
    logic [5:0]  cfg_len = '0;
    logic [15:0] cfg_gap = '0;
    logic [1:0]  cfg_last = '0;
    logic [7:0]  cfg_loops = '0;
    logic        start = 1'b0;
    logic        ser_out, busy, done;
    logic [7:0]  loop_idx;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] m_word [4];
    int          m_len  [4];
    int          m_gap  [4];

    localparam int MAXT = 2048;
    bit exp_bit  [MAXT];
    bit exp_gapc [MAXT];
    int exp_loop [MAXT];
    int exp_t;

    always #2 clk = ~clk;

    cmdseq_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_word(cfg_word), .cfg_len(cfg_len), .cfg_gap(cfg_gap),
        .cfg_last(cfg_last), .cfg_loops(cfg_loops), .start(start),
        .ser_out(ser_out), .busy(busy), .done(done), .loop_idx(loop_idx)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic write_slot(input int s, input logic [31:0] w, input int l, input int g,
                              input bit model);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_slot = 2'(s); cfg_word = w; cfg_len = 6'(l); cfg_gap = 16'(g);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (model) begin
            m_word[s] = w; m_len[s] = l; m_gap[s] = g;
        end
    endtask

    task automatic build(input int loops, input int last);
        exp_t = 0;
        for (int lp = 0; lp < loops; lp++) begin
            for (int s = 0; s <= last; s++) begin
                int L;
                L = (m_len[s] > 32) ? 32 : m_len[s];
                if (L == 0) begin
                    exp_bit[exp_t] = 1'b0; exp_gapc[exp_t] = 1'b0; exp_loop[exp_t] = lp; exp_t++;
                end else begin
                    for (int b = L - 1; b >= 0; b--) begin
                        exp_bit[exp_t] = m_word[s][b]; exp_gapc[exp_t] = 1'b0;
                        exp_loop[exp_t] = lp; exp_t++;
                    end
                end
                for (int g = 0; g < m_gap[s]; g++) begin
                    exp_bit[exp_t] = 1'b0; exp_gapc[exp_t] = 1'b1; exp_loop[exp_t] = lp; exp_t++;
                end
            end
        end
    endtask

    // Start a run and compare every cycle; optional start pulse and slot write mid-run
    task automatic run(input int loops, input int last, input bit poke_start, input bit poke_write);
        build(loops, last);
        @(posedge clk); #1;
        cfg_loops = 8'(loops); cfg_last = 2'(last); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int i = 0; i <= exp_t + 1; i++) begin
            @(negedge clk);
            if (i < exp_t) begin
                if (poke_start)      check("R9 ser_out", ser_out, exp_bit[i]);
                else if (exp_gapc[i]) check("R5 gap line low", ser_out, 0);
                else                 check("R4 command bit", ser_out, exp_bit[i]);
                check("R3 busy during run", busy, 1);
                check("R6 loop_idx", loop_idx, exp_loop[i]);
                check("R7 no early done", done, 0);
            end else if (i == exp_t) begin
                check(loops == 0 ? "R8 immediate done" : "R7 done pulse", done, 1);
                check("R7 busy low with done", busy, 0);
                check("R5 idle line low", ser_out, 0);
            end else begin
                check("R7 done one cycle", done, 0);
            end
            if (poke_start && i == 3) start = 1'b1;
            if (poke_start && i == 4) start = 1'b0;
            if (poke_write && i == 2) begin
                cfg_we = 1'b1; cfg_slot = 2'd0; cfg_word = 32'h0000_0000;
                cfg_len = 6'd3; cfg_gap = 16'd9;
            end
            if (poke_write && i == 3) cfg_we = 1'b0;
        end
    endtask

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 busy reset", busy, 0);
        check("R1 done reset", done, 0);
        check("R1 ser_out reset", ser_out, 0);
        check("R1 loop_idx reset", loop_idx, 0);

        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < 4; s++) begin
                logic [31:0] w;
                int l, g;
                w = 32'hA5C3_0F96 ^ (32'h1357_9BDF * (p * 4 + s + 1));
                case (p)
                    0: begin l = (s == 0) ? 1 : (s == 1) ? 5 : (s == 2) ? 32 : 0;
                             g = (s == 0) ? 0 : (s == 1) ? 2 : (s == 2) ? 1 : 3; end
                    1: begin l = (s == 0) ? 40 : (s == 1) ? 3 : (s == 2) ? 0 : 7;
                             g = (s == 0) ? 1 : (s == 1) ? 0 : (s == 2) ? 0 : 2; end
                    default: begin l = (s == 0) ? 8 : (s == 1) ? 32 : (s == 2) ? 2 : 1;
                             g = (s == 0) ? 3 : (s == 1) ? 1 : 0; end
                endcase
                write_slot(s, w, l, g, 1'b1);   // R2 stored while idle
            end
            for (int lp = 0; lp < 4; lp++)
                for (int last = 0; last < 4; last++)
                    run(lp, last, 1'b0, 1'b0);
        end

        run(2, 3, 1'b1, 1'b0);  // R9 start while busy ignored
        run(2, 1, 1'b0, 1'b1);  // R2 write during run ignored
        run(1, 1, 1'b0, 1'b0);  // R2 slot 0 still holds the old contents
        write_slot(0, 32'h0000_0005, 3, 4, 1'b1);
        run(1, 0, 1'b0, 1'b0);  // R2 new contents after idle write

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule